// File: doc/BRIEF.md
# Page Whitening Value Allocator

This block hands out a 10-bit whitening value each time a memory page is allocated. It keeps one entry per page. Each entry holds the next value to issue, a flag that records that the sequential range is used up, and a valid bit. While an entry is in its sequential phase, an allocation returns the stored value and then increments it. Every page therefore walks through all 1024 values exactly once. After that walk the entry switches to random values for good. These come from a built-in 16-bit linear feedback shift register, so ciphertext keeps changing even when a page is reallocated with the same plaintext.

Requests arrive on a valid/ready stream that carries a page number. Each accepted request produces exactly one response beat, one cycle later, on a second valid/ready stream. A response that is not taken is held, and no new request is accepted until it drains. A plain clear input invalidates every entry in one cycle. After a clear, each page starts again from value 0 with its overflow flag cleared.

Top module: `wv_alloc`

## Requirements
- R1: After reset `rsp_valid` is low, `req_ready` is high, and every page is invalid, so its first allocation returns 0.
- R2: Allocating a page whose entry is invalid returns value 0 with `rsp_rand`=0 and `rsp_ovf`=0, and stores 1 as that page's next value.
- R3: Allocating a valid page that has not overflowed returns its stored value with `rsp_rand`=0, and stores that value plus one.
- R4: The allocation that returns 1023 sets the page's overflow flag and wraps the stored value to 0 in the same update. Its response carries `rsp_ovf`=1.
- R5: Every allocation of an overflowed page returns bits [9:0] of the random register as it stood in the accepting cycle, with `rsp_rand`=1 and `rsp_ovf`=1. The random register starts at 16'hACE1 when reset is released and advances on every clock: the new state is {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R6: `rsp_valid` rises in the cycle after a request is accepted. `rsp_page` echoes the request's page. While `rsp_ready` is low, `rsp_valid`, `rsp_wval`, `rsp_rand` and `rsp_ovf` hold steady.
- R7: `req_ready` equals (not `rsp_valid` or `rsp_ready`) and not `clr`. A request is accepted only when `req_valid` and `req_ready` are both high.
- R8: A cycle with `clr` high invalidates every entry and clears its overflow flag. That cycle accepts no request.
- R9: Each page's entry changes only when that page is allocated or a clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Invalidate all entries this cycle |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Block can accept a request |
| req_page | input | 8 | Page number to allocate |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_page | output | 8 | Page the response belongs to |
| rsp_wval | output | 10 | Whitening value issued |
| rsp_rand | output | 1 | Value came from the random register |
| rsp_ovf | output | 1 | Page's overflow flag after this allocation |

## Verification
The assertions assume a consumer that obeys the stream rules. They also assume that `clr` may arrive in any cycle, including while a response is waiting. They do not depend on the consumer holding `req_page` steady, because the page is captured only at acceptance. The stimulus drives inputs half a cycle away from the sampling edge. It keeps `rsp_ready` high except in a directed back-pressure phase, and it issues clears only between requests. This keeps the bench's reference table and reference random register aligned with the accepting cycles.

// File: rtl/wv_pkg.sv
package wv_pkg;
  parameter int WV_W = 10;

  typedef struct packed {
    logic            vld;
    logic            ovf;
    logic [WV_W-1:0] nxt;
  } wv_entry_t;
endpackage

// File: rtl/wv_lfsr.sv
module wv_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R5
  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> state[W-1:1] == $past(state[W-2:0])); // R5
endmodule

// File: rtl/wv_table.sv
module wv_table
  import wv_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  wv_entry_t         wr_ent,
  input  logic [PAGE_W-1:0] rd_page,
  output wv_entry_t         rd_ent
);
  localparam int DEPTH = 1 << PAGE_W;

  wv_entry_t ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      ent[g] <= '0;
      else if (clr)                                    ent[g] <= '0;
      else if (wr_en && wr_page == PAGE_W'(g))         ent[g] <= wr_ent;
    end
  end

  assign rd_ent = ent[rd_page];

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rd_ent.vld && !rd_ent.ovf); // R8
  AST_NO_WRITE_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !wr_en); // R8
endmodule

// File: rtl/wv_next.sv
module wv_next
  import wv_pkg::*;
(
  input  wv_entry_t         cur,
  input  logic [WV_W-1:0]   rnd,
  output logic [WV_W-1:0]   out_val,
  output logic              out_rand,
  output wv_entry_t         upd
);
  localparam logic [WV_W-1:0] TOP = '1;

  always_comb begin
    upd      = cur;
    out_val  = '0;
    out_rand = 1'b0;
    if (!cur.vld) begin
      upd.vld = 1'b1;
      upd.ovf = 1'b0;
      upd.nxt = WV_W'(1);
    end else if (cur.ovf) begin
      out_val  = rnd;
      out_rand = 1'b1;
    end else begin
      out_val = cur.nxt;
      upd.nxt = cur.nxt + WV_W'(1);
      if (cur.nxt == TOP) upd.ovf = 1'b1;
    end
  end
endmodule

// File: rtl/wv_alloc.sv
module wv_alloc
  import wv_pkg::*;
#(
  parameter int          PAGE_W    = 8,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PAGE_W-1:0] rsp_page,
  output logic [WV_W-1:0]   rsp_wval,
  output logic              rsp_rand,
  output logic              rsp_ovf
);
  logic [LFSR_W-1:0] lfsr;
  wv_entry_t         cur_ent, upd_ent;
  logic [WV_W-1:0]   nv;
  logic              nrand;
  logic              accept;

  assign req_ready = (!rsp_valid || rsp_ready) && !clr;
  assign accept    = req_valid && req_ready;

  wv_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0]), .SEED(LFSR_SEED[LFSR_W-1:0])) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr)
  );

  wv_table #(.PAGE_W(PAGE_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(accept), .wr_page(req_page), .wr_ent(upd_ent),
    .rd_page(req_page), .rd_ent(cur_ent)
  );

  wv_next u_nxt (
    .cur(cur_ent), .rnd(lfsr[WV_W-1:0]),
    .out_val(nv), .out_rand(nrand), .upd(upd_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_page  <= '0;
      rsp_wval  <= '0;
      rsp_rand  <= 1'b0;
      rsp_ovf   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_page  <= req_page;
      rsp_wval  <= nv;
      rsp_rand  <= nrand;
      rsp_ovf   <= upd_ent.ovf;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_wval) && $stable(rsp_rand) && $stable(rsp_ovf)); // R6
  AST_CLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !req_ready); // R7
  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cur_ent.vld |=> rsp_wval == '0 && !rsp_rand && !rsp_ovf); // R2
  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cur_ent.vld && !cur_ent.ovf && (&cur_ent.nxt) |=> rsp_ovf && (&rsp_wval)); // R4
  AST_OVF_RANDOM: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cur_ent.ovf |=> rsp_rand && rsp_ovf); // R5
endmodule

// File: tb/tb_wv_alloc.sv
module tb_wv_alloc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_page = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_page;
  logic [9:0] rsp_wval;
  logic       rsp_rand;
  logic       rsp_ovf;

  int checks = 0;
  int fails  = 0;

  logic [9:0]  m_nxt [256];
  logic        m_ovf [256];
  logic        m_vld [256];
  logic [15:0] m_lf;

  always #4 clk = ~clk;

  wv_alloc dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_page(rsp_page),
    .rsp_wval(rsp_wval), .rsp_rand(rsp_rand), .rsp_ovf(rsp_ovf)
  );

  // reference random register, R5
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lf <= 16'hACE1;
    else        m_lf <= {m_lf[14:0], m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10]};
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 256; i++) begin
      m_nxt[i] = '0; m_ovf[i] = 1'b0; m_vld[i] = 1'b0;
    end
  endfunction

  // computes expected value/rand/ovf and updates the model
  function automatic void model_alloc(input int p, input logic [15:0] lf,
                                      output int ev, output int er, output int eo);
    if (!m_vld[p]) begin
      ev = 0; er = 0; m_vld[p] = 1'b1; m_nxt[p] = 10'd1; eo = 0;
    end else if (m_ovf[p]) begin
      ev = int'(lf[9:0]); er = 1; eo = 1;
    end else begin
      ev = int'(m_nxt[p]); er = 0;
      if (m_nxt[p] == 10'd1023) m_ovf[p] = 1'b1;
      m_nxt[p] = m_nxt[p] + 10'd1;
      eo = int'(m_ovf[p]);
    end
  endfunction

  task automatic alloc(input int p, input string req, input bit do_chk);
    int ev, er, eo;
    @(negedge clk);
    req_valid = 1'b1;
    req_page  = 8'(p);
    while (!req_ready) @(negedge clk);
    model_alloc(p, m_lf, ev, er, eo);
    @(negedge clk);
    req_valid = 1'b0;
    if (do_chk || int'(rsp_wval) != ev) begin
      chk({req, " rsp_valid"}, int'(rsp_valid), 1);
      chk({req, " rsp_page"}, int'(rsp_page), p);
      chk({req, " wval"}, int'(rsp_wval), ev);
      chk({req, " rand"}, int'(rsp_rand), er);
      chk({req, " ovf"}, int'(rsp_ovf), eo);
    end else begin
      chk(req, int'({rsp_valid, rsp_rand, rsp_ovf}), int'({1'b1, er[0], eo[0]}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);

    alloc(5, "R1 R2 first alloc", 1'b1);
    alloc(5, "R3 second alloc", 1'b1);
    alloc(6, "R9 other page first", 1'b1);
    alloc(5, "R3 third alloc", 1'b1);

    // walk page 7 through its whole range and beyond
    for (int i = 0; i < 1023; i++) alloc(7, "R3 walk", 1'b0);
    alloc(7, "R4 last sequential", 1'b1);
    alloc(7, "R5 first random", 1'b1);
    repeat (int'($urandom_range(1, 5))) @(negedge clk);
    alloc(7, "R5 second random", 1'b1);
    alloc(5, "R9 page 5 unaffected", 1'b1);

    // back-pressure, R6 R7
    @(negedge clk);
    rsp_ready = 1'b0;
    alloc(9, "R6 held response", 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 still valid", int'(rsp_valid), 1);
      chk("R6 value stable", int'(rsp_wval), 0);
      chk("R7 ready low under back-pressure", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    #1;
    chk("R7 ready follows rsp_ready", int'(req_ready), 1);
    @(negedge clk);
    chk("R6 drained", int'(rsp_valid), 0);

    // clear, R8
    @(negedge clk);
    clr = 1'b1;
    req_valid = 1'b1;
    req_page = 8'd7;
    #1;
    chk("R8 R7 ready low during clear", int'(req_ready), 0);
    @(negedge clk);
    clr = 1'b0;
    req_valid = 1'b0;
    chk("R8 no response from clear cycle", int'(rsp_valid), 0);
    model_clear();
    alloc(7, "R8 overflowed page restarts", 1'b1);
    alloc(5, "R8 page restarts", 1'b1);

    // constrained random traffic on a few pages
    for (int n = 0; n < 1500; n++) begin
      int p;
      p = int'($urandom_range(0, 7)) * 31;
      alloc(p, "R3 R9 random traffic", 1'b0);
      if ($urandom_range(0, 9) == 0) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule